// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the slave side of an 8-bit parallel host bus. It gives an external microprocessor read and write access to a file of byte registers held inside the chip. Two static strap inputs configure it. The first picks the strobe style. In Intel style, separate read and write strobes are each qualified by chip select. In Motorola style, a single data strobe is qualified by chip select and its direction comes from a read/write line. The second strap picks where the address comes from: either the shared data bus, caught while an address-latch-enable pulse is high, or a dedicated address bus.

The host strobes are asynchronous to the chip, so they pass through a synchronizer clocked by the local master clock. A strobe counts as a real access only once it has been seen active for long enough. Each access then produces one single-cycle internal pulse, which neighbouring logic can also see:

- a read pulse when a read begins;
- a write pulse when a write ends.

A ready output tells the host that its access has been seen. A control register bit selects between two qualification modes:

- a strict mode that needs two consecutive active samples;
- a fast mode that accepts one sample.

Top module: `hbus_slave`

## Requirements
- R1: In Intel style (`intel_mode_i`=1) a write is active only while `wr_n_i` and `cs_n_i` are both low, and a read only while `rd_n_i` and `cs_n_i` are both low. Strobes with `cs_n_i` high cause no write pulse, leave the registers unchanged and never raise `ad_oe_o`.
- R2: In Motorola style (`intel_mode_i`=0) an access is active while `ds_n_i` and `cs_n_i` are both low. It is a write when `rw_i`=0 and a read when `rw_i`=1. A read access produces no write pulse.
- R3: With `muxed_i`=1 the address follows `ad_i` while `ale_i` is high. After `ale_i` falls the address holds, whatever `ad_i` later carries, until the next `ale_i` pulse.
- R4: With `muxed_i`=0 the address is taken from `addr_i`, and `ad_i` carries only data.
- R5: In strict mode (control bit 0 = 0, the reset value) a strobe is accepted only after it has been seen active at two consecutive synchronized clock samples. A strobe that lasts a single clock period is ignored.
- R6: Writing 1 to bit 0 of the register at address 0x0F selects fast mode. In fast mode a single synchronized sample is enough, so a one-period strobe performs its write.
- R7: Each accepted write gives exactly one `wr_stb_o` pulse, one cycle long, after the strobe ends. While the pulse is high, `acc_addr_o` and `wr_data_o` show the address and the data present at the end of the strobe. The register takes the new value.
- R8: Each accepted read gives exactly one `rd_stb_o` pulse when the read is accepted. For the whole read strobe, `ad_o` carries the addressed register and `ad_oe_o` is high. `ad_oe_o` is low whenever no read strobe is active.
- R9: `ready_o` is high while an accepted strobe is still active and low otherwise. A write pulse is always preceded by `ready_o` high.
- R10: `rst_n_i` low asynchronously clears every register, including the mode bit, and its release is synchronized to `clk_i`. No access pulse appears during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Active-low reset, asynchronous assert |
| intel_mode_i | input | 1 | Strap: 1 = Intel strobes, 0 = Motorola strobes |
| muxed_i | input | 1 | Strap: 1 = address on shared bus, 0 = separate address bus |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Intel read strobe, active low |
| wr_n_i | input | 1 | Intel write strobe, active low |
| ds_n_i | input | 1 | Motorola data strobe, active low |
| rw_i | input | 1 | Motorola direction: 1 read, 0 write |
| ale_i | input | 1 | Address latch enable, active high |
| ad_i | input | 8 | Shared address/data bus, input side |
| addr_i | input | 8 | Separate address bus |
| ad_o | output | 8 | Read data toward the host |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |
| ready_o | output | 1 | Access has been accepted |
| wr_stb_o | output | 1 | One-cycle internal write pulse |
| rd_stb_o | output | 1 | One-cycle internal read pulse |
| acc_addr_o | output | 8 | Address of the current access |
| wr_data_o | output | 8 | Data of the current write |

## Verification
Writes and reads are run in both strobe styles and both address sources, with distinct values at distinct addresses. This shows that decoding and address selection pick the right register, not just any register. Strobes with chip select held high, and reads in Motorola style, show that the write path separates a true write from other strobe activity. A one-period strobe is driven in strict mode and then again in fast mode, and the different outcomes tell the two qualification modes apart. In multiplexed mode, unrelated values are placed on the shared bus after the latch pulse to show that the address is held, and a reset in mid-run shows that the mode bit and the contents are cleared.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic {
      QUAL_STRICT = 1'b0,
      QUAL_FAST   = 1'b1
   } qual_mode_e;

   typedef struct packed {
      logic wr;
      logic rd;
   } hbus_req_t;

   localparam int REQ_W = $bits(hbus_req_t);

endpackage

// File: rtl/hbus_rst_sync.sv
module hbus_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   output logic rst_n_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbus_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
   import hbus_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              intel_mode_i,
   input  logic              muxed_i,
   input  logic              cs_n_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   input  logic              ds_n_i,
   input  logic              rw_i,
   input  logic              ale_i,
   input  logic [ADDR_W-1:0] ad_addr_i,
   input  logic [ADDR_W-1:0] sep_addr_i,
   output hbus_req_t         req_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] held_q;

   always_comb begin
      if (intel_mode_i) begin
         req_o.wr = !cs_n_i && !wr_n_i;
         req_o.rd = !cs_n_i && !rd_n_i;
      end else begin
         req_o.wr = !cs_n_i && !ds_n_i && !rw_i;
         req_o.rd = !cs_n_i && !ds_n_i &&  rw_i;
      end
   end

   // Address capture: follows the shared bus while ALE is high, holds after.
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)   held_q <= '0;
      else if (ale_i) held_q <= ad_addr_i;
   end

   always_comb begin
      if (!muxed_i)   addr_o = sep_addr_i;
      else if (ale_i) addr_o = ad_addr_i;
      else            addr_o = held_q;
   end
endmodule

// File: rtl/hbus_qual.sv
module hbus_qual
   import hbus_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  qual_mode_e        mode_i,
   input  hbus_req_t         raw_i,
   input  hbus_req_t         sync_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              wr_stb_o,
   output logic              rd_stb_o,
   output logic              ready_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);
   hbus_req_t prev_q, acc, acc_q;
   logic      fast;

   assign fast = (mode_i == QUAL_FAST);

   always_comb begin
      acc.wr = sync_i.wr && (fast || prev_q.wr);
      acc.rd = sync_i.rd && (fast || prev_q.rd);
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         prev_q     <= '0;
         acc_q      <= '0;
         acc_addr_o <= '0;
         wr_data_o  <= '0;
      end else begin
         prev_q <= sync_i;
         acc_q  <= acc;
         if (raw_i.wr || raw_i.rd) begin
            acc_addr_o <= addr_i;
            wr_data_o  <= data_i;
         end
      end
   end

   assign wr_stb_o = acc_q.wr && !acc.wr;
   assign rd_stb_o = acc.rd && !acc_q.rd;
   assign ready_o  = acc.wr || acc.rd;
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0F
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              mode_bit_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o    = mem_q[raddr_i];
   assign mode_bit_o = mem_q[CTRL_ADDR][0];
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
   import hbus_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h0F
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              intel_mode_i,
   input  logic              muxed_i,
   input  logic              cs_n_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   input  logic              ds_n_i,
   input  logic              rw_i,
   input  logic              ale_i,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe_o,
   output logic              ready_o,
   output logic              wr_stb_o,
   output logic              rd_stb_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);
   generate
      if (ADDR_W != DATA_W) begin : g_bad_width
         $error("hbus_slave: shared bus needs ADDR_W == DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hbus_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rst_n_s;
   hbus_req_t         raw_req, sync_req;
   logic [ADDR_W-1:0] cur_addr;
   logic              mode_bit;

   hbus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_n_s)
   );

   hbus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk_i(clk_i), .rst_n_i(rst_n_s),
      .intel_mode_i(intel_mode_i), .muxed_i(muxed_i),
      .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
      .ds_n_i(ds_n_i), .rw_i(rw_i), .ale_i(ale_i),
      .ad_addr_i(ad_i), .sep_addr_i(addr_i),
      .req_o(raw_req), .addr_o(cur_addr)
   );

   hbus_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_n_i(rst_n_s), .d_i(raw_req), .q_o(sync_req)
   );

   hbus_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qual (
      .clk_i(clk_i), .rst_n_i(rst_n_s),
      .mode_i(qual_mode_e'(mode_bit)),
      .raw_i(raw_req), .sync_i(sync_req),
      .addr_i(cur_addr), .data_i(ad_i),
      .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o), .ready_o(ready_o),
      .acc_addr_o(acc_addr_o), .wr_data_o(wr_data_o)
   );

   hbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
      .clk_i(clk_i), .rst_n_i(rst_n_s),
      .we_i(wr_stb_o), .waddr_i(acc_addr_o), .wdata_i(wr_data_o),
      .raddr_i(cur_addr), .rdata_o(ad_o), .mode_bit_o(mode_bit)
   );

   assign ad_oe_o = raw_req.rd;
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk (
   input logic clk_i,
   input logic rst_n_i,
   input logic cs_n_i,
   input logic ad_oe_o,
   input logic ready_o,
   input logic wr_stb_o,
   input logic rd_stb_o
);
   // R7: write pulse lasts one cycle
   a_r7_wr_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wr_stb_o |=> !wr_stb_o);

   // R8: read pulse lasts one cycle
   a_r8_rd_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rd_stb_o |=> !rd_stb_o);

   // R8: bus driven only with chip select active
   a_r8_oe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ad_oe_o |-> !cs_n_i);

   // R9: read accepted only with ready high
   a_r9_rd_ready: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rd_stb_o |-> ready_o);

   // R9: write pulse preceded by ready
   a_r9_wr_after_ready: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wr_stb_o |-> $past(ready_o));

   // R1/R2: never both pulses at once
   a_r1_stb_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(wr_stb_o && rd_stb_o));

   // R10: reset keeps the pulses quiet
   a_r10_quiet_reset: assert property (@(posedge clk_i)
      !rst_n_i |=> (!wr_stb_o && !rd_stb_o));
endmodule

bind hbus_slave hbus_slave_chk u_chk (
   .clk_i(clk_i), .rst_n_i(rst_n_i), .cs_n_i(cs_n_i), .ad_oe_o(ad_oe_o),
   .ready_o(ready_o), .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o)
);

// File: tb/sim_hbus_slave.sv
module sim_hbus_slave;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       intel = 1'b1, muxed = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rw = 1'b1, ale = 1'b0;
   logic [7:0] ad = 8'h00, addr = 8'h00;
   logic [7:0] ad_o, acc_addr, wr_data;
   logic       ad_oe, ready, wr_stb, rd_stb;

   int checks = 0, errors = 0;
   int wr_cnt = 0, rd_cnt = 0;
   logic rdy_seen = 1'b0, oe_seen = 1'b0;
   logic [7:0] last_a = 8'h00, last_d = 8'h00, rd_val = 8'h00;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hbus_slave u0 (
      .clk_i(clk), .rst_n_i(rst_n), .intel_mode_i(intel), .muxed_i(muxed),
      .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .ds_n_i(ds_n), .rw_i(rw),
      .ale_i(ale), .ad_i(ad), .addr_i(addr), .ad_o(ad_o), .ad_oe_o(ad_oe),
      .ready_o(ready), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb),
      .acc_addr_o(acc_addr), .wr_data_o(wr_data)
   );

   always @(negedge clk) begin
      if (wr_stb) begin wr_cnt++; last_a = acc_addr; last_d = wr_data; end
      if (rd_stb) rd_cnt++;
      if (ready)  rdy_seen = 1'b1;
      if (ad_oe)  oe_seen = 1'b1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One host access; len = strobe length in clock periods.
   task automatic xfer(input logic is_wr, input logic [7:0] a, input logic [7:0] d,
                       input int len, input logic cs_on);
      wr_cnt = 0; rd_cnt = 0; rdy_seen = 1'b0; oe_seen = 1'b0;
      if (muxed) begin
         ad = a; ale = 1'b1; cycles(2);
         ale = 1'b0; cycles(1);
         ad = is_wr ? d : 8'hEE;
      end else begin
         addr = a; ad = is_wr ? d : 8'hEE;
      end
      rw = !is_wr;
      cycles(1);
      cs_n = !cs_on;
      if (intel) begin
         if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
      end else ds_n = 1'b0;
      cycles(len);
      rd_val = ad_o;
      cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; ds_n = 1'b1;
      cycles(6);
   endtask

   task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      xfer(1'b0, a, 8'h00, 6, 1'b1);
      check(req, rd_val, exp);
   endtask

   task automatic t_reset;
      check("R10 ready after reset", ready, 1'b0);
      check("R10 oe after reset", ad_oe, 1'b0);
      read_chk("R10 ctrl reg cleared", 8'h0F, 8'h00);
      read_chk("R10 reg 0x21 cleared", 8'h21, 8'h00);
   endtask

   task automatic t_intel;
      intel = 1'b1; muxed = 1'b0;
      xfer(1'b1, 8'h21, 8'h5A, 6, 1'b1);
      check("R7 one write pulse", wr_cnt, 1);
      check("R7 pulse address", last_a, 8'h21);
      check("R7 pulse data", last_d, 8'h5A);
      check("R9 ready during write", rdy_seen, 1'b1);
      check("R9 ready low after", ready, 1'b0);
      xfer(1'b0, 8'h21, 8'h00, 6, 1'b1);
      check("R8 read data", rd_val, 8'h5A);
      check("R8 one read pulse", rd_cnt, 1);
      check("R8 oe during read", oe_seen, 1'b1);
      check("R8 no write on read", wr_cnt, 0);
      check("R8 oe low after", ad_oe, 1'b0);
   endtask

   task automatic t_cs;
      intel = 1'b1; muxed = 1'b0;
      xfer(1'b1, 8'h21, 8'hFF, 6, 1'b0);
      check("R1 no write without cs", wr_cnt, 0);
      xfer(1'b0, 8'h21, 8'h00, 6, 1'b0);
      check("R1 no oe without cs", oe_seen, 1'b0);
      read_chk("R1 reg unchanged", 8'h21, 8'h5A);
   endtask

   task automatic t_moto;
      intel = 1'b0; muxed = 1'b0;
      xfer(1'b1, 8'h33, 8'hC3, 6, 1'b1);
      check("R2 moto write pulse", wr_cnt, 1);
      xfer(1'b0, 8'h33, 8'h00, 6, 1'b1);
      check("R2 moto read data", rd_val, 8'hC3);
      check("R2 moto read no write", wr_cnt, 0);
      check("R2 moto read pulse", rd_cnt, 1);
      intel = 1'b1;
   endtask

   task automatic t_mux;
      intel = 1'b1; muxed = 1'b1;
      xfer(1'b1, 8'h44, 8'h99, 6, 1'b1);
      check("R3 mux pulse address", last_a, 8'h44);
      read_chk("R3 mux read back", 8'h44, 8'h99);
      read_chk("R3 data value not used as address", 8'h99, 8'h00);
      muxed = 1'b0;
   endtask

   task automatic t_sep;
      intel = 1'b1; muxed = 1'b0;
      xfer(1'b1, 8'h55, 8'h12, 6, 1'b1);
      read_chk("R4 separate address", 8'h55, 8'h12);
      read_chk("R4 data bus not address", 8'h12, 8'h00);
   endtask

   task automatic t_short;
      xfer(1'b1, 8'h21, 8'h77, 1, 1'b1);
      check("R5 short strobe ignored", wr_cnt, 0);
      read_chk("R5 reg unchanged", 8'h21, 8'h5A);
   endtask

   task automatic t_fast;
      xfer(1'b1, 8'h0F, 8'h01, 6, 1'b1);
      read_chk("R6 mode bit set", 8'h0F, 8'h01);
      xfer(1'b1, 8'h21, 8'h77, 1, 1'b1);
      check("R6 short strobe accepted", wr_cnt, 1);
      read_chk("R6 short write landed", 8'h21, 8'h77);
      xfer(1'b1, 8'h0F, 8'h00, 6, 1'b1);
      xfer(1'b1, 8'h21, 8'h66, 1, 1'b1);
      check("R5 strict again after clear", wr_cnt, 0);
   endtask

   task automatic t_midreset;
      xfer(1'b1, 8'h0F, 8'h01, 6, 1'b1);
      rst_n = 1'b0; cycles(2);
      rst_n = 1'b1; cycles(4);
      read_chk("R10 reg cleared by reset", 8'h21, 8'h00);
      read_chk("R10 mode cleared by reset", 8'h0F, 8'h00);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(5);
      t_reset();
      t_intel();
      t_cs();
      t_moto();
      t_mux();
      t_sep();
      t_short();
      t_fast();
      t_midreset();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule